// File: doc/BRIEF.md
# Load Queue Ordering-Violation Detector

This block tracks loads that are in flight in a processor core and keeps the ordering between loads correct while letting them finish out of order. Loads take a slot in a circular queue in program order. They may complete in any order: a younger load that hits in the cache does not wait behind an older load that missed. Each completion records the cache line the load read and whether it was a write-combining access. Loads leave from the head once they have completed.

Because younger loads may have read their data before older ones, any coherence notice for a line they read could make the result visible out of order. Every incoming invalidation and every eviction of a line from the private caches is compared against the line addresses of all queued loads. When such a notice hits a completed, ordinary load while some older load is still incomplete, the block raises a one-cycle machine-clear pulse naming the oldest such load. The queue rolls its tail back to that slot, so the violating load and everything younger are dropped and the issue side reissues them. Only line addresses are compared. Data values play no part, so a store that rewrites the same value still causes a clear.

Top module: `lqv_order_guard`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, `clear_o` is 0 and `head_done_o` is 0.
- R2: An allocation is accepted when `alloc_valid_i` and `alloc_ready_o` are both 1. It takes slot `alloc_idx_o`, and the next slot index is one higher, modulo DEPTH. `alloc_ready_o` is 0 exactly while DEPTH loads are held, and an allocation request then changes nothing.
- R3: A snoop with `snoop_valid_i` = 1 is a violation when its `snoop_line_i` equals the line of a valid load that has completed with `cmpl_wc_i` = 0, and some older valid load in the queue has not completed. On a violation `clear_o` is 1 in the following cycle only. On a snoop that is not a violation, or on a snoop whose line differs from every stored line, `clear_o` stays 0.
- R4: When several loads qualify, `clear_idx_o` gives the oldest one, with age counted from the head, including when the queue wraps past the last slot.
- R5: A load completed with `cmpl_wc_i` = 1 never qualifies as a violator.
- R6: On a violation, the violating slot and every younger slot become invalid, and `alloc_idx_o` equals `clear_idx_o` in the cycle `clear_o` is 1. An allocation accepted in the detection cycle is discarded with them. A completion in that cycle to a discarded slot has no effect.
- R7: `snoop_kind_i` = 0 (invalidate) and `snoop_kind_i` = 1 (evict) are checked in the same way.
- R8: A completion for a load in the same cycle as a matching snoop counts that load as not yet completed. No violation is raised for it, and it still counts as an older incomplete load for younger entries.
- R9: `head_done_o` is 1 when the head slot holds a completed load. `retire_i` frees the head only then. Otherwise `retire_i` has no effect.
- R10: A completion to an index that holds no valid load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Request to allocate the next load in program order |
| alloc_ready_o | output | 1 | Queue has a free slot |
| alloc_idx_o | output | IDX_W | Slot the next allocation takes (tail) |
| cmpl_valid_i | input | 1 | A load has completed |
| cmpl_idx_i | input | IDX_W | Slot of the completing load |
| cmpl_line_i | input | LINE_W | Line address the load read |
| cmpl_wc_i | input | 1 | Load was a write-combining access |
| retire_i | input | 1 | Request to free the head slot |
| head_done_o | output | 1 | Head slot holds a completed load |
| snoop_valid_i | input | 1 | Coherence notice present |
| snoop_line_i | input | LINE_W | Line address of the notice |
| snoop_kind_i | input | 1 | 0 invalidate, 1 evict |
| clear_o | output | 1 | One-cycle machine-clear pulse |
| clear_idx_o | output | IDX_W | Slot of the oldest violating load |

## Verification
The bench aims at the age ordering across the wrap point. A picker that ranks by raw slot number instead of age from the head reports a younger load, and the bench catches this when two loads qualify on either side of the last slot. It also drives a completion in the same cycle as a matching snoop. A design that forwards the new completion would raise a spurious clear there, and one that forgets the load afterwards would miss the clear on the next snoop. Write-combining loads, eviction notices, snoops that match nothing, allocation while the queue is full and retirement of an incomplete head are each checked. A design that gets any of these wrong either clears when it must not or lets the tail and head pointers drift. A long random phase compares every output against a reference model on every clock, which exposes mistakes in how the tail rolls back and in discarding allocations made in the detection cycle.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
   typedef enum logic {
      SNP_INVAL = 1'b0,
      SNP_EVICT = 1'b1
   } snoop_kind_e;
endpackage

// File: rtl/lqv_entry_array.sv
module lqv_entry_array #(
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4,
   parameter int LINE_W = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_we,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic              cmpl_we,
   input  logic [IDX_W-1:0]  cmpl_idx,
   input  logic [LINE_W-1:0] cmpl_line,
   input  logic              cmpl_wc,
   input  logic              free_we,
   input  logic [IDX_W-1:0]  free_idx,
   input  logic [DEPTH-1:0]  kill_mask,
   input  logic [LINE_W-1:0] snoop_line,
   output logic [DEPTH-1:0]  hit_vec,
   output logic [DEPTH-1:0]  pend_vec,
   output logic [DEPTH-1:0]  settled_vec
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      localparam logic [IDX_W-1:0] MY = IDX_W'(g);
      logic              v_q;
      logic              d_q;
      logic              w_q;
      logic [LINE_W-1:0] l_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            w_q <= 1'b0;
            l_q <= '0;
         end else if (kill_mask[g]) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else begin
            if (alloc_we && alloc_idx == MY) begin
               v_q <= 1'b1;
               d_q <= 1'b0;
            end else if (free_we && free_idx == MY) begin
               v_q <= 1'b0;
               d_q <= 1'b0;
            end else if (cmpl_we && cmpl_idx == MY && v_q) begin
               d_q <= 1'b1;
               w_q <= cmpl_wc;
               l_q <= cmpl_line;
            end
         end
      end

      assign hit_vec[g]     = v_q & d_q & ~w_q & (l_q == snoop_line);
      assign pend_vec[g]    = v_q & ~d_q;
      assign settled_vec[g] = v_q & d_q;
   end
endmodule

// File: rtl/lqv_oldest_pick.sv
module lqv_oldest_pick #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] head,
   input  logic [DEPTH-1:0] hit_vec,
   input  logic [DEPTH-1:0] pend_vec,
   output logic             found,
   output logic [IDX_W-1:0] pick_age,
   output logic [IDX_W-1:0] pick_idx
);
   logic [DEPTH-1:0] rot_hit;
   logic [DEPTH-2:0] rot_pend;
   logic [DEPTH-1:0] older;
   logic [DEPTH-1:0] cand;

   for (genvar k = 0; k < DEPTH; k++) begin : g_rot
      wire [IDX_W-1:0] src = head + IDX_W'(k);
      assign rot_hit[k] = hit_vec[src];
      if (k < DEPTH - 1) begin : g_pend
         assign rot_pend[k] = pend_vec[src];
      end
   end

   assign older[0] = 1'b0;
   for (genvar k = 1; k < DEPTH; k++) begin : g_chain
      assign older[k] = older[k-1] | rot_pend[k-1];
   end

   assign cand = rot_hit & older;

   always_comb begin
      pick_age = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (cand[k]) pick_age = IDX_W'(k);
      end
   end

   assign found    = |cand;
   assign pick_idx = head + pick_age;
endmodule

// File: rtl/lqv_ptr_ctrl.sv
module lqv_ptr_ctrl #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic             retire_fire,
   input  logic             rollback,
   input  logic [IDX_W-1:0] rollback_age,
   output logic [IDX_W-1:0] head_q,
   output logic [IDX_W-1:0] tail_q,
   output logic             full
);
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q <= head_q + IDX_W'(retire_fire);
         if (rollback) begin
            tail_q  <= head_q + rollback_age;
            count_q <= CNT_W'(rollback_age) - CNT_W'(retire_fire);
         end else begin
            tail_q  <= tail_q + IDX_W'(alloc_fire);
            count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
         end
      end
   end

   assign full = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lqv_order_guard.sv
module lqv_order_guard #(
   parameter int DEPTH          = 16,
   parameter int ADDR_W         = 40,
   parameter int LINE_BYTES     = 64,
   parameter bit EVICT_AS_INVAL = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid_i,
   output logic              alloc_ready_o,
   output logic [IDX_W-1:0]  alloc_idx_o,
   input  logic              cmpl_valid_i,
   input  logic [IDX_W-1:0]  cmpl_idx_i,
   input  logic [LINE_W-1:0] cmpl_line_i,
   input  logic              cmpl_wc_i,
   input  logic              retire_i,
   output logic              head_done_o,
   input  logic              snoop_valid_i,
   input  logic [LINE_W-1:0] snoop_line_i,
   input  logic              snoop_kind_i,
   output logic              clear_o,
   output logic [IDX_W-1:0]  clear_idx_o
);
   import lqv_pkg::*;

   localparam int CNT_W = IDX_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LINE_BYTES < 1 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [IDX_W-1:0] head_q;
   logic [IDX_W-1:0] tail_q;
   logic             full;
   logic [DEPTH-1:0] hit_vec;
   logic [DEPTH-1:0] pend_vec;
   logic [DEPTH-1:0] settled_vec;
   logic [DEPTH-1:0] kill_mask;
   logic             found;
   logic [IDX_W-1:0] pick_age;
   logic [IDX_W-1:0] pick_idx;
   logic             snoop_chk;
   logic             violation;
   logic             alloc_fire;
   logic             retire_fire;
   logic             clear_q;
   logic [IDX_W-1:0] clear_idx_q;

   // Which notice kinds enter the comparison.
   if (EVICT_AS_INVAL) begin : g_both_kinds
      assign snoop_chk = snoop_valid_i &
                         (snoop_kind_e'(snoop_kind_i) == SNP_INVAL ||
                          snoop_kind_e'(snoop_kind_i) == SNP_EVICT);
   end else begin : g_inval_only
      assign snoop_chk = snoop_valid_i &
                         (snoop_kind_e'(snoop_kind_i) == SNP_INVAL);
   end

   assign violation   = snoop_chk & found;
   assign alloc_fire  = alloc_valid_i & ~full;
   assign head_done_o = settled_vec[head_q];
   assign retire_fire = retire_i & head_done_o;

   // Squash the violator and everything younger than it.
   for (genvar i = 0; i < DEPTH; i++) begin : g_kill
      wire [IDX_W-1:0] age = IDX_W'(i) - head_q;
      assign kill_mask[i] = violation & (age >= pick_age);
   end

   lqv_entry_array #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .LINE_W(LINE_W)
   ) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_we   (alloc_fire),
      .alloc_idx  (tail_q),
      .cmpl_we    (cmpl_valid_i),
      .cmpl_idx   (cmpl_idx_i),
      .cmpl_line  (cmpl_line_i),
      .cmpl_wc    (cmpl_wc_i),
      .free_we    (retire_fire),
      .free_idx   (head_q),
      .kill_mask  (kill_mask),
      .snoop_line (snoop_line_i),
      .hit_vec    (hit_vec),
      .pend_vec   (pend_vec),
      .settled_vec(settled_vec)
   );

   lqv_oldest_pick #(
      .DEPTH(DEPTH),
      .IDX_W(IDX_W)
   ) u_pick (
      .head    (head_q),
      .hit_vec (hit_vec),
      .pend_vec(pend_vec),
      .found   (found),
      .pick_age(pick_age),
      .pick_idx(pick_idx)
   );

   lqv_ptr_ctrl #(
      .DEPTH(DEPTH),
      .IDX_W(IDX_W),
      .CNT_W(CNT_W)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .retire_fire (retire_fire),
      .rollback    (violation),
      .rollback_age(pick_age),
      .head_q      (head_q),
      .tail_q      (tail_q),
      .full        (full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clear_q     <= 1'b0;
         clear_idx_q <= '0;
      end else begin
         clear_q <= violation;
         if (violation) clear_idx_q <= pick_idx;
      end
   end

   assign alloc_ready_o = ~full;
   assign alloc_idx_o   = tail_q;
   assign clear_o       = clear_q;
   assign clear_idx_o   = clear_idx_q;
endmodule

// File: rtl/lqv_order_guard_chk.sv
module lqv_order_guard_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid_i,
   input logic             alloc_ready_o,
   input logic [IDX_W-1:0] alloc_idx_o,
   input logic             retire_i,
   input logic             head_done_o,
   input logic             snoop_valid_i,
   input logic             clear_o,
   input logic [IDX_W-1:0] clear_idx_o,
   input logic [IDX_W-1:0] head_q
);
   // R3: a clear only follows a snoop
   a_r3_clear_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |-> $past(snoop_valid_i));

   // R3: the head has nothing older, so it is never the violator
   a_r3_never_head: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |-> clear_idx_o != $past(head_q));

   // R6: tail rolled back to the violating slot
   a_r6_tail_rollback: assert property (@(posedge clk) disable iff (!rst_n)
      clear_o |-> alloc_idx_o == clear_idx_o);

   // R2: a request while full leaves the tail alone
   a_r2_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid_i && !alloc_ready_o && !snoop_valid_i) |=> $stable(alloc_idx_o));

   // R9: an incomplete head is never freed
   a_r9_no_early_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !head_done_o) |=> $stable(head_q));
endmodule

bind lqv_order_guard lqv_order_guard_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/lqv_order_guard_tb_top.sv
module lqv_order_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int IDX_W      = 4;
   localparam int LINE_W     = 34;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_valid_i = 1'b0;
   logic              alloc_ready_o;
   logic [IDX_W-1:0]  alloc_idx_o;
   logic              cmpl_valid_i = 1'b0;
   logic [IDX_W-1:0]  cmpl_idx_i = '0;
   logic [LINE_W-1:0] cmpl_line_i = '0;
   logic              cmpl_wc_i = 1'b0;
   logic              retire_i = 1'b0;
   logic              head_done_o;
   logic              snoop_valid_i = 1'b0;
   logic [LINE_W-1:0] snoop_line_i = '0;
   logic              snoop_kind_i = 1'b0;
   logic              clear_o;
   logic [IDX_W-1:0]  clear_idx_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lqv_order_guard dut_i (.*);

   // Reference model state
   bit              m_v [DEPTH];
   bit              m_d [DEPTH];
   bit              m_w [DEPTH];
   logic [LINE_W-1:0] m_ln [DEPTH];
   int m_head, m_tail, m_cnt;
   bit m_clear;
   int m_cidx;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_w[i] = 0; m_ln[i] = '0;
         end
         m_head = 0; m_tail = 0; m_cnt = 0; m_clear = 0; m_cidx = 0;
      end else begin
         int vk, vi, h0;
         bit older, ret;
         vk = -1; vi = 0; older = 0; h0 = m_head;
         if (snoop_valid_i) begin
            for (int k = 0; k < DEPTH; k++) begin
               int i;
               i = (h0 + k) % DEPTH;
               if (m_v[i]) begin
                  if (vk < 0 && m_d[i] && !m_w[i] && m_ln[i] == snoop_line_i && older) begin
                     vk = k; vi = i;
                  end
                  if (!m_d[i]) older = 1;
               end
            end
         end
         ret = retire_i && m_v[h0] && m_d[h0];
         if (cmpl_valid_i && m_v[cmpl_idx_i]) begin
            int age;
            age = (int'(cmpl_idx_i) - h0 + DEPTH) % DEPTH;
            if (vk < 0 || age < vk) begin
               m_d[cmpl_idx_i] = 1; m_w[cmpl_idx_i] = cmpl_wc_i; m_ln[cmpl_idx_i] = cmpl_line_i;
            end
         end
         if (alloc_valid_i && m_cnt < DEPTH) begin
            m_v[m_tail] = 1; m_d[m_tail] = 0;
            m_tail = (m_tail + 1) % DEPTH; m_cnt++;
         end
         if (ret) begin
            m_v[h0] = 0; m_d[h0] = 0;
            m_head = (h0 + 1) % DEPTH; m_cnt--;
         end
         if (vk >= 0) begin
            for (int a = vk; a < DEPTH; a++) begin
               m_v[(h0 + a) % DEPTH] = 0; m_d[(h0 + a) % DEPTH] = 0;
            end
            m_tail = vi;
            m_cnt = vk - int'(ret);
         end
         m_clear = (vk >= 0);
         if (vk >= 0) m_cidx = vi;
      end
   end

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare_model();
      check("R2 ready vs model", alloc_ready_o, m_cnt < DEPTH);
      check("R2/R6 alloc index vs model", alloc_idx_o, m_tail);
      check("R9 head done vs model", head_done_o, m_v[m_head] && m_d[m_head]);
      check("R3 clear vs model", clear_o, m_clear);
      if (m_clear) check("R4 clear index vs model", clear_idx_o, m_cidx);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_model();
      alloc_valid_i = 0; cmpl_valid_i = 0; retire_i = 0; snoop_valid_i = 0;
      cmpl_wc_i = 0; snoop_kind_i = 0;
   endtask

   task automatic do_alloc();
      alloc_valid_i = 1; tick();
   endtask

   task automatic do_cmpl(int idx, int line, bit wc);
      cmpl_valid_i = 1; cmpl_idx_i = IDX_W'(idx); cmpl_line_i = LINE_W'(line); cmpl_wc_i = wc;
      tick();
   endtask

   task automatic do_snoop(int line, bit kind);
      snoop_valid_i = 1; snoop_line_i = LINE_W'(line); snoop_kind_i = kind;
      tick();
   endtask

   task automatic do_retire();
      retire_i = 1; tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 ready after reset", alloc_ready_o, 1);
      check("R1 alloc index after reset", alloc_idx_o, 0);
      check("R1 clear after reset", clear_o, 0);
      check("R1 head done after reset", head_done_o, 0);

      // Basic violation: slot 0 pending, 1 and 2 done on line 0x10
      for (int i = 0; i < 4; i++) do_alloc();
      check("R2 tail after four allocations", alloc_idx_o, 4);
      do_cmpl(1, 'h10, 0);
      do_cmpl(2, 'h10, 0);
      do_cmpl(3, 'h20, 0);
      do_snoop('h10, 0);
      check("R3 clear raised", clear_o, 1);
      check("R4 oldest violator", clear_idx_o, 1);
      check("R6 tail rolled back", alloc_idx_o, 1);
      tick();
      check("R3 clear lasts one cycle", clear_o, 0);

      // No older pending load: no clear
      do_cmpl(0, 'h30, 0);
      do_alloc();
      do_cmpl(1, 'h10, 0);
      do_snoop('h10, 0);
      check("R3 no clear without older pending", clear_o, 0);
      check("R9 head done", head_done_o, 1);
      do_retire();
      do_retire();
      check("R9 empty after retiring both", head_done_o, 0);

      // Write-combining exemption: slot 2 pending, 3 done as WC
      do_alloc();
      do_alloc();
      do_cmpl(3, 'h40, 1);
      do_snoop('h40, 0);
      check("R5 write-combining load exempt", clear_o, 0);
      // Eviction notice treated as an invalidation
      do_alloc();
      do_cmpl(4, 'h40, 0);
      do_snoop('h40, 1);
      check("R7 eviction raises clear", clear_o, 1);
      check("R7 eviction violator index", clear_idx_o, 4);

      // Completion in the same cycle as a matching snoop
      do_alloc();
      cmpl_valid_i = 1; cmpl_idx_i = 4; cmpl_line_i = 'h50; cmpl_wc_i = 0;
      snoop_valid_i = 1; snoop_line_i = 'h50;
      tick();
      check("R8 same-cycle completion not violating", clear_o, 0);
      do_snoop('h51, 0);
      check("R3 different line does not match", clear_o, 0);
      do_snoop('h50, 0);
      check("R8 later snoop sees the completed load", clear_o, 1);
      check("R8 later snoop index", clear_idx_o, 4);

      // Ignored completion to an empty slot, then retire rules
      do_cmpl(9, 'h50, 0);
      do_snoop('h50, 0);
      check("R10 completion to empty slot ignored", clear_o, 0);
      do_retire();
      check("R9 retire of pending head has no effect", head_done_o, 0);
      do_cmpl(2, 'h70, 0);
      check("R9 head still present after failed retire", head_done_o, 1);
      do_retire();
      do_retire();
      check("R9 queue empty", head_done_o, 0);
      check("R2 tail at slot 4", alloc_idx_o, 4);

      // Fill to wrap, then a violation across the wrap
      for (int i = 0; i < DEPTH; i++) do_alloc();
      check("R2 not ready when full", alloc_ready_o, 0);
      do_alloc();
      check("R2 full request ignored", alloc_idx_o, 4);
      do_cmpl(4, 'h50, 0);
      do_cmpl(2, 'h60, 0);
      do_cmpl(1, 'h60, 0);
      do_snoop('h60, 0);
      check("R4 oldest across the wrap", clear_idx_o, 1);
      check("R6 tail after wrapped clear", alloc_idx_o, 1);
      check("R2 ready after rollback", alloc_ready_o, 1);

      // Violation with allocation and squashed completion in the same cycle
      do_alloc();
      do_cmpl(6, 'h70, 0);
      alloc_valid_i = 1;
      snoop_valid_i = 1; snoop_line_i = 'h70;
      cmpl_valid_i = 1; cmpl_idx_i = 7; cmpl_line_i = 'h71;
      tick();
      check("R6 clear with same-cycle allocation", clear_idx_o, 6);
      check("R6 allocation discarded", alloc_idx_o, 6);

      // Random phase compared with the model every cycle
      for (int n = 0; n < 4000; n++) begin
         alloc_valid_i = ($urandom % 3) != 0;
         cmpl_valid_i  = ($urandom % 2) != 0;
         cmpl_idx_i    = IDX_W'($urandom);
         cmpl_line_i   = LINE_W'($urandom % 4);
         cmpl_wc_i     = ($urandom % 6) == 0;
         retire_i      = ($urandom % 3) == 0;
         snoop_valid_i = ($urandom % 4) == 0;
         snoop_line_i  = LINE_W'($urandom % 4);
         snoop_kind_i  = $urandom % 2;
         tick();
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule